// File: doc/BRIEF.md
# Security-Scaled Interrupt Priority Array

This block holds one 8-bit priority for each of 32 private interrupts and presents all of them in parallel to the selection logic downstream. A simple register bus reaches the array. Each request carries an address, a byte-or-word size flag, write data and a secure attribute. A byte request touches one priority. A word request touches four neighbouring priorities, and the lowest-numbered interrupt sits in the least significant byte.

Two inputs shape every access. The first is a global security-disable level. The second is a per-interrupt group vector, where a bit of 1 marks the interrupt as Group 1 and a bit of 0 marks it as Group 0. A non-secure request made while security-disable is low is called a restricted access here. A restricted access cannot see or change a Group 0 priority. For a Group 1 priority it works through a compressed view: a write is halved and forced into the upper half of the range, and a read is shifted back up by one bit. All other accesses move the raw stored byte. Each byte of a word request is screened and converted on its own.

After every write request the block raises a one-cycle pulse, so that the selection logic knows to re-evaluate.

Top module: `prio_sec_array`

## Requirements
- R1: After reset every stored priority is 0x00, and rdValid and prioChanged are low.
- R2: A byte request at address k addresses the priority of interrupt k (k = 0..31).
- R3: A word request covers interrupts b..b+3, with interrupt b in rdData/reqWdata bits [7:0], where b is the address with its two low bits cleared.
- R4: A secure request, or any request while secDisable is 1, writes and reads the raw stored byte.
- R5: A restricted access (reqSecure=0, secDisable=0) reads a Group 0 entry (groupVec bit 0) as 0x00.
- R6: A restricted write to a Group 0 entry leaves that stored priority unchanged.
- R7: A restricted read of a Group 1 entry returns the stored byte shifted left by one, truncated to 8 bits.
- R8: A restricted write to a Group 1 entry stores 0x80 OR (written byte >> 1).
- R9: In a word write, each of the four bytes is screened and converted on its own, so a single word write can update some entries and leave the others unchanged.
- R10: rdValid is high for exactly the cycle after a read request, and rdData carries the result in that cycle. For a byte read, rdData[31:8] is zero.
- R11: prioChanged is high for exactly the cycle after each write request, including a write whose bytes are all blocked. New priorities are visible on prioFlat in that same cycle.
- R12: prioFlat bits [8k+7:8k] always carry the stored priority of interrupt k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = four-byte access, 0 = single byte |
| reqAddr | input | 5 | Byte address within the array |
| reqWdata | input | 32 | Write data; a byte write uses bits [7:0] |
| reqSecure | input | 1 | Secure attribute of the request |
| secDisable | input | 1 | Global security-disable level |
| groupVec | input | 32 | Group per interrupt, 1 = Group 1 |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| prioChanged | output | 1 | One-cycle pulse after a write |
| prioFlat | output | 256 | All 32 priorities, interrupt k at [8k+7:8k] |

## Verification
The assertions assume that groupVec, secDisable and reqSecure stay steady from the cycle of a request until its result is checked. They also assume that no request touches an interrupt index beyond the array. The bench changes the group vector and the security-disable level only while the bus is idle. It uses only in-range addresses and keeps each request to a single cycle, so the one-cycle windows of the assertions line up with the write and read paths.

// File: rtl/prio_pkg.sv
package prio_pkg;
  parameter int unsigned LANES     = 4;
  parameter int unsigned MAX_IDX_W = 8;

  typedef struct packed {
    logic [LANES-1:0]     laneWr;
    logic [LANES-1:0]     laneRd;
    logic [MAX_IDX_W-1:0] baseIdx;
    logic                 restricted;
    logic                 rdCapture;
    logic                 wrPulse;
  } strobe_t;
endpackage

// File: rtl/prio_lane_xform.sv
module prio_lane_xform #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              restricted,
  input  logic              isGroup1,
  input  logic [PRIO_W-1:0] stored,
  input  logic [PRIO_W-1:0] wrByte,
  output logic [PRIO_W-1:0] viewByte,
  output logic [PRIO_W-1:0] storeByte,
  output logic              wrAllow
);
  logic hidden;

  always_comb begin
    hidden = restricted && !isGroup1;
    if (hidden) begin
      viewByte = '0;
    end else if (restricted) begin
      viewByte = {stored[PRIO_W-2:0], 1'b0};
    end else begin
      viewByte = stored;
    end
    storeByte = restricted ? {1'b1, wrByte[PRIO_W-1:1]} : wrByte;
    wrAllow   = !hidden;
  end
endmodule

// File: rtl/prio_ctrl.sv
module prio_ctrl
  import prio_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqWord,
  input  logic [IDX_W-1:0] reqAddr,
  input  logic             reqSecure,
  input  logic             secDisable,
  output strobe_t          stb,
  output logic             rdValid,
  output logic             prioChanged
);
  localparam int unsigned LANE_BITS = $clog2(LANES);

  logic [IDX_W-1:0] alignedAddr;
  logic [LANES-1:0] laneSel;
  logic             rdValidQ;
  logic             changedQ;

  always_comb begin
    alignedAddr = reqAddr;
    laneSel     = '0;
    if (reqWord) begin
      alignedAddr[LANE_BITS-1:0] = '0;
      laneSel = '1;
    end else begin
      laneSel[0] = 1'b1;
    end
  end

  always_comb begin
    stb            = '0;
    stb.baseIdx    = MAX_IDX_W'(alignedAddr);
    stb.restricted = !reqSecure && !secDisable;
    stb.laneWr     = (reqValid && reqWrite) ? laneSel : '0;
    stb.laneRd     = laneSel;
    stb.rdCapture  = reqValid && !reqWrite;
    stb.wrPulse    = reqValid && reqWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      changedQ <= 1'b0;
    end else begin
      rdValidQ <= stb.rdCapture;
      changedQ <= stb.wrPulse;
    end
  end

  assign rdValid     = rdValidQ;
  assign prioChanged = changedQ;
endmodule

// File: rtl/prio_datapath.sv
module prio_datapath
  import prio_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IDX_W   = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [PRIO_W*LANES-1:0]   wdata,
  input  logic [NUM_IRQ-1:0]        groupVec,
  output logic [PRIO_W*LANES-1:0]   rdData,
  output logic [NUM_IRQ*PRIO_W-1:0] prioFlat
);
  localparam int unsigned DATA_W = PRIO_W * LANES;

  logic [PRIO_W-1:0] mem      [NUM_IRQ];
  logic [IDX_W-1:0]  laneIdx  [LANES];
  logic [PRIO_W-1:0] laneView [LANES];
  logic [PRIO_W-1:0] laneStore[LANES];
  logic [LANES-1:0]  laneAllow;
  logic [DATA_W-1:0] rdNext;
  logic [DATA_W-1:0] rdQ;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneIdx[l] = stb.baseIdx[IDX_W-1:0] + IDX_W'(l);

    prio_lane_xform #(.PRIO_W(PRIO_W)) u_xform (
      .restricted(stb.restricted),
      .isGroup1  (groupVec[laneIdx[l]]),
      .stored    (mem[laneIdx[l]]),
      .wrByte    (wdata[l*PRIO_W +: PRIO_W]),
      .viewByte  (laneView[l]),
      .storeByte (laneStore[l]),
      .wrAllow   (laneAllow[l])
    );

    assign rdNext[l*PRIO_W +: PRIO_W] = stb.laneRd[l] ? laneView[l] : '0;
  end

  for (genvar j = 0; j < NUM_IRQ; j++) begin : g_entry
    logic              hit;
    logic [PRIO_W-1:0] hitData;

    always_comb begin
      hit     = 1'b0;
      hitData = '0;
      for (int l = 0; l < LANES; l++) begin
        if (stb.laneWr[l] && laneAllow[l] && (laneIdx[l] == IDX_W'(j))) begin
          hit     = 1'b1;
          hitData = laneStore[l];
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mem[j] <= '0;
      end else if (hit) begin
        mem[j] <= hitData;
      end
    end

    assign prioFlat[j*PRIO_W +: PRIO_W] = mem[j];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (stb.rdCapture) begin
      rdQ <= rdNext;
    end
  end

  assign rdData = rdQ;
endmodule

// File: rtl/prio_sec_array.sv
module prio_sec_array
  import prio_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ),
  localparam int unsigned DATA_W = PRIO_W * LANES
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic                      reqWord,
  input  logic [IDX_W-1:0]          reqAddr,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic                      reqSecure,
  input  logic                      secDisable,
  input  logic [NUM_IRQ-1:0]        groupVec,
  output logic                      rdValid,
  output logic [DATA_W-1:0]         rdData,
  output logic                      prioChanged,
  output logic [NUM_IRQ*PRIO_W-1:0] prioFlat
);
  strobe_t stb;

  prio_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqWord    (reqWord),
    .reqAddr    (reqAddr),
    .reqSecure  (reqSecure),
    .secDisable (secDisable),
    .stb        (stb),
    .rdValid    (rdValid),
    .prioChanged(prioChanged)
  );

  prio_datapath #(
    .NUM_IRQ(NUM_IRQ),
    .PRIO_W (PRIO_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wdata   (reqWdata),
    .groupVec(groupVec),
    .rdData  (rdData),
    .prioFlat(prioFlat)
  );
endmodule

// File: rtl/prio_sec_array_chk.sv
module prio_sec_array_chk #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned DATA_W  = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqValid,
  input logic                      reqWrite,
  input logic                      reqWord,
  input logic [IDX_W-1:0]          reqAddr,
  input logic [DATA_W-1:0]         reqWdata,
  input logic                      reqSecure,
  input logic                      secDisable,
  input logic [NUM_IRQ-1:0]        groupVec,
  input logic                      rdValid,
  input logic [DATA_W-1:0]         rdData,
  input logic                      prioChanged,
  input logic [NUM_IRQ*PRIO_W-1:0] prioFlat
);
  logic              restrictedReq;
  logic              byteWr;
  logic              byteRd;
  logic [PRIO_W-1:0] entNow;
  logic [IDX_W-1:0]  lastAddr;
  logic [PRIO_W-1:0] lastEntry;
  logic [PRIO_W-1:0] lastByte;

  assign restrictedReq = !reqSecure && !secDisable;
  assign byteWr        = reqValid && reqWrite && !reqWord;
  assign byteRd        = reqValid && !reqWrite && !reqWord;
  assign entNow        = prioFlat[reqAddr*PRIO_W +: PRIO_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddr  <= '0;
      lastEntry <= '0;
      lastByte  <= '0;
    end else begin
      lastAddr  <= reqAddr;
      lastEntry <= entNow;
      lastByte  <= reqWdata[PRIO_W-1:0];
    end
  end

  // R11
  p_pulse_after_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> prioChanged);
  p_no_pulse_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |=> !prioChanged);
  // R10
  p_read_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rdValid);
  p_no_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rdValid);
  p_byte_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    byteRd |=> (rdData[DATA_W-1:PRIO_W] == '0));
  // R6
  p_hidden_write_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (byteWr && restrictedReq && !groupVec[reqAddr])
      |=> (prioFlat[lastAddr*PRIO_W +: PRIO_W] == lastEntry));
  // R8
  p_ns_store_scaled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (byteWr && restrictedReq && groupVec[reqAddr])
      |=> (prioFlat[lastAddr*PRIO_W +: PRIO_W] == {1'b1, lastByte[PRIO_W-1:1]}));
  // R4
  p_raw_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    (byteWr && !restrictedReq) |=> (prioFlat[lastAddr*PRIO_W +: PRIO_W] == lastByte));
  // R5
  p_hidden_read_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (byteRd && restrictedReq && !groupVec[reqAddr]) |=> (rdData == '0));
endmodule

bind prio_sec_array prio_sec_array_chk #(
  .NUM_IRQ(NUM_IRQ),
  .PRIO_W (PRIO_W),
  .IDX_W  (IDX_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqWord    (reqWord),
  .reqAddr    (reqAddr),
  .reqWdata   (reqWdata),
  .reqSecure  (reqSecure),
  .secDisable (secDisable),
  .groupVec   (groupVec),
  .rdValid    (rdValid),
  .rdData     (rdData),
  .prioChanged(prioChanged),
  .prioFlat   (prioFlat)
);

// File: tb/tb_prio_sec_array.sv
`timescale 1ns/1ps
module tb_prio_sec_array;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic         reqWord = 1'b0;
  logic [4:0]   reqAddr = '0;
  logic [31:0]  reqWdata = '0;
  logic         reqSecure = 1'b1;
  logic         secDisable = 1'b0;
  logic [31:0]  groupVec = '0;
  logic         rdValid;
  logic [31:0]  rdData;
  logic         prioChanged;
  logic [255:0] prioFlat;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] model [32];
  logic [31:0] gotData;
  logic        gotValid;
  logic        gotChanged;

  prio_sec_array dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqSecure(reqSecure), .secDisable(secDisable), .groupVec(groupVec),
    .rdValid(rdValid), .rdData(rdData), .prioChanged(prioChanged),
    .prioFlat(prioFlat)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung act=%0d exp<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkFlat(input string tag);
    logic ok = 1'b1;
    for (int k = 0; k < 32; k++)
      if (prioFlat[k*8 +: 8] !== model[k]) begin
        ok = 1'b0;
        $display("FAIL %s entry %0d act=%h exp=%h", tag, k, prioFlat[k*8 +: 8], model[k]);
      end
    checks++;
    if (!ok) errors++;
  endtask

  function automatic logic restr(input logic sec);
    return !sec && !secDisable;
  endfunction

  function automatic logic [7:0] viewOf(input int k, input logic sec);
    if (restr(sec) && !groupVec[k]) return 8'h00;
    if (restr(sec)) return {model[k][6:0], 1'b0};
    return model[k];
  endfunction

  function automatic logic [31:0] expRead(input logic word, input logic [4:0] a, input logic sec);
    logic [31:0] v = '0;
    int b;
    if (!word) begin
      v[7:0] = viewOf(a, sec);
    end else begin
      b = {a[4:2], 2'b00};
      for (int l = 0; l < 4; l++) v[l*8 +: 8] = viewOf(b + l, sec);
    end
    return v;
  endfunction

  task automatic modelWrite(input logic word, input logic [4:0] a, input logic [31:0] d, input logic sec);
    int b, n;
    b = word ? {a[4:2], 2'b00} : a;
    n = word ? 4 : 1;
    for (int l = 0; l < n; l++) begin
      if (restr(sec)) begin
        if (groupVec[b + l]) model[b + l] = 8'h80 | (d[l*8 +: 8] >> 1);
      end else begin
        model[b + l] = d[l*8 +: 8];
      end
    end
  endtask

  task automatic busOp(input logic wr, input logic word, input logic [4:0] a,
                       input logic [31:0] d, input logic sec);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWord = word; reqAddr = a;
    reqWdata = d; reqSecure = sec;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    gotData = rdData; gotValid = rdValid; gotChanged = prioChanged;
    if (wr) modelWrite(word, a, d, sec);
  endtask

  task automatic doRead(input string tag, input logic word, input logic [4:0] a, input logic sec);
    busOp(1'b0, word, a, 32'h0, sec);
    chk({tag, " R10 valid"}, {31'b0, gotValid}, 32'd1);
    chk(tag, gotData, expRead(word, a, sec));
  endtask

  task automatic testReset();
    chkFlat("R1 reset prioFlat");
    chk("R1 reset rdValid", {31'b0, rdValid}, 32'd0);
    chk("R1 reset prioChanged", {31'b0, prioChanged}, 32'd0);
  endtask

  task automatic testSecureByte();
    busOp(1'b1, 1'b0, 5'd5, 32'hFFFF_FF3C, 1'b1);
    chk("R11 pulse after write", {31'b0, gotChanged}, 32'd1);
    chkFlat("R12 R2 byte write visible same cycle as pulse");
    @(negedge clk);
    chk("R11 pulse one cycle", {31'b0, prioChanged}, 32'd0);
    chk("R10 rdValid idle", {31'b0, rdValid}, 32'd0);
    doRead("R2 byte read k=5", 1'b0, 5'd5, 1'b1);
    chk("R10 byte upper zero", {8'h0, gotData[31:8]}, 32'd0);
    busOp(1'b1, 1'b0, 5'd31, 32'h0000_00E1, 1'b1);
    chkFlat("R2 top entry");
  endtask

  task automatic testWord();
    busOp(1'b1, 1'b1, 5'd8, 32'h4433_2211, 1'b1);
    chkFlat("R3 word write lanes");
    chk("R3 lane0 is irq8", {24'h0, prioFlat[8*8 +: 8]}, 32'h11);
    doRead("R3 byte read irq11", 1'b0, 5'd11, 1'b1);
    doRead("R3 word read unaligned addr", 1'b1, 5'd10, 1'b1);
    chk("R3 word value", gotData, 32'h4433_2211);
  endtask

  task automatic testRestricted();
    groupVec = 32'h0000_F0F0;
    busOp(1'b1, 1'b0, 5'd4, 32'h0000_0040, 1'b0);
    chk("R8 stored scaled", {24'h0, prioFlat[4*8 +: 8]}, 32'hA0);
    chkFlat("R8 flat");
    doRead("R7 shifted read", 1'b0, 5'd4, 1'b0);
    chk("R7 value", gotData, 32'h40);
    busOp(1'b1, 1'b0, 5'd0, 32'h0000_0077, 1'b1);
    busOp(1'b1, 1'b0, 5'd0, 32'h0000_0055, 1'b0);
    chk("R11 pulse on blocked write", {31'b0, gotChanged}, 32'd1);
    chk("R6 hidden write ignored", {24'h0, prioFlat[7:0]}, 32'h77);
    doRead("R5 hidden read", 1'b0, 5'd0, 1'b0);
    chk("R5 value", gotData, 32'h0);
    busOp(1'b1, 1'b0, 5'd31, 32'h0000_00FF, 1'b0);
    chkFlat("R6 R2 top entry hidden");
  endtask

  task automatic testWordMix();
    groupVec = 32'h0000_0A00;
    busOp(1'b1, 1'b1, 5'd8, 32'hFFEE_DDCC, 1'b0);
    chk("R9 irq8 kept", {24'h0, prioFlat[8*8 +: 8]}, 32'h11);
    chk("R9 irq9 scaled", {24'h0, prioFlat[9*8 +: 8]}, 32'hEE);
    chk("R9 irq10 kept", {24'h0, prioFlat[10*8 +: 8]}, 32'h33);
    chk("R9 irq11 scaled", {24'h0, prioFlat[11*8 +: 8]}, 32'hFF);
    chkFlat("R9 flat");
    doRead("R9 R7 restricted word read", 1'b1, 5'd8, 1'b0);
    doRead("R4 secure word read raw", 1'b1, 5'd8, 1'b1);
  endtask

  task automatic testSecDisable();
    secDisable = 1'b1;
    groupVec = 32'h0;
    busOp(1'b1, 1'b0, 5'd2, 32'h0000_0013, 1'b0);
    chk("R4 raw ns store", {24'h0, prioFlat[2*8 +: 8]}, 32'h13);
    doRead("R4 raw ns read", 1'b0, 5'd2, 1'b0);
    chk("R4 value", gotData, 32'h13);
    busOp(1'b1, 1'b1, 5'd20, 32'h8070_6050, 1'b0);
    chkFlat("R4 raw ns word");
    secDisable = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 32; k++) model[k] = 8'h00;
    #1;
    testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSecureByte();
    testWord();
    testRestricted();
    testWordMix();
    testSecDisable();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule